// File: doc/BRIEF.md
# Low-Power Scan Slice Encoding Selector

The block sits in front of a reconfigurable scan decompressor. Each accepted input slice has one care bit and one value bit for every internal scan chain. The block tries four pin-sharing arrangements. Under arrangement k, chain c is fed by pin `c mod m_k`, where m is 2, 3, 5 and 7 for codes 0 to 3.

For each arrangement the block does four things:
- It checks that the slice can be encoded.
- It fills every chain from its pin.
- It counts how many cells change against the slice shifted in before.
- It ranks the arrangement by the objective that is selected.

The winner's code, the pin values to drive and the filled slice are registered and presented on an output handshake. When no arrangement works, a serial-delivery flag is raised.

The state held between slices is the last filled slice and the last driven pin values. Reset clears both to zero, which stands for a captured response of all zeros. Pins that the winning arrangement does not use keep their old value.

Top module: `scan_cfg_selector`

## Requirements
- R1: After reset, `out_valid_o` is 0, `ready_o` is 1, and `slice_o` and `pins_o` are all zeros.
- R2: An arrangement is usable only if every care bit on chains that share one pin has the same value. When none is usable, `serial_o` is 1 and `cfg_o` is 0.
- R3: In every accepted result, each chain whose care bit is set shows its care value in `slice_o`.
- R4: Under an arrangement of modulus m, a pin p < m whose chain group has care bits drives that care value. A group with no care bits repeats the pin's previous value. Pins at index m and above keep their previous value.
- R5: For a non-serial result, chain c of `slice_o` equals `pins_o[c mod m]`, with m = 2, 3, 5, 7 for `cfg_o` = 0, 1, 2, 3.
- R6: With `obj_i` = 1 (power), the winner is the usable arrangement with the fewest chains that differ from the previous slice. Ties go to fewer pins.
- R7: With `obj_i` = 0 (compression), the winner is the usable arrangement with the fewest pins, which is the smallest modulus.
- R8: With `obj_i` = 2 or 3 (combined), the winner minimises transitions × pins. Ties go to fewer transitions, then to the lower code.
- R9: The previous-slice state is loaded with every accepted result. A serial result fills chains without care bits from the previous slice and leaves `pins_o` unchanged.
- R10: While `out_valid_o` is 1 and `out_ready_i` is 0, `ready_o` is 0, no slice is taken, and all outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input slice offered |
| ready_o | output | 1 | Input slice can be taken |
| care_i | input | N_CHAINS | Care mask, one bit per chain |
| value_i | input | N_CHAINS | Care values, one bit per chain |
| obj_i | input | 2 | Objective: 0 compression, 1 power, 2/3 combined |
| out_valid_o | output | 1 | Result held on outputs |
| out_ready_i | input | 1 | Result consumed |
| serial_o | output | 1 | No usable arrangement; deliver serially |
| cfg_o | output | 2 | Winning arrangement code |
| pins_o | output | 7 | Scan-in pin values to drive |
| slice_o | output | N_CHAINS | Filled slice, also the previous-slice state |

## Verification
The checker makes the following assumptions:
- `valid_i` is low while reset is asserted.
- Care and value inputs matter only in the cycle a slice is accepted.
- Value bits under a cleared care bit have no effect on the result.

The bench drives stimulus on the falling edge and drops `valid_i` between slices, so the inputs present at each accepting edge are the ones being checked. Care masks are drawn at several densities, so that the results cover several usable arrangements per slice, single winners and fully conflicting slices. The objective cycles through all four codes.

// File: rtl/scan_cfg_sel_pkg.sv
package scan_cfg_sel_pkg;
  localparam int unsigned NUM_CFG  = 4;
  localparam int unsigned MAX_PINS = 7;
  localparam int unsigned CFG_W    = 2;

  typedef enum logic [1:0] {
    OBJ_PINS  = 2'd0,
    OBJ_TRAN  = 2'd1,
    OBJ_PROD  = 2'd2,
    OBJ_PROD2 = 2'd3
  } obj_e;

  function automatic int unsigned cfg_modulus(input int unsigned k);
    case (k)
      0:       return 2;
      1:       return 3;
      2:       return 5;
      default: return 7;
    endcase
  endfunction
endpackage

// File: rtl/scan_cfg_eval.sv
module scan_cfg_eval
  import scan_cfg_sel_pkg::*;
#(
  parameter int unsigned N_CHAINS = 14,
  parameter int unsigned MODULUS  = 2,
  parameter int unsigned CNT_W    = 4
) (
  input  logic [N_CHAINS-1:0] care_i,
  input  logic [N_CHAINS-1:0] value_i,
  input  logic [N_CHAINS-1:0] prev_slice_i,
  input  logic [MAX_PINS-1:0] prev_pins_i,
  output logic                ok_o,
  output logic [MAX_PINS-1:0] pins_o,
  output logic [N_CHAINS-1:0] fill_o,
  output logic [CNT_W-1:0]    tran_o
);
  logic [MODULUS-1:0]  has1, has0;
  logic [N_CHAINS-1:0] diff;

  always_comb begin
    has1 = '0;
    has0 = '0;
    for (int c = 0; c < N_CHAINS; c++) begin
      if (care_i[c]) begin
        if (value_i[c]) has1[c % MODULUS] = 1'b1;
        else            has0[c % MODULUS] = 1'b1;
      end
    end
    ok_o = ~|(has1 & has0);
    // unused and care-free pins repeat their last value
    pins_o = prev_pins_i;
    for (int p = 0; p < MODULUS; p++) begin
      if (has1[p] | has0[p]) pins_o[p] = has1[p];
    end
    for (int c = 0; c < N_CHAINS; c++) fill_o[c] = pins_o[c % MODULUS];
    diff   = fill_o ^ prev_slice_i;
    tran_o = '0;
    for (int c = 0; c < N_CHAINS; c++) tran_o = tran_o + CNT_W'(diff[c]);
  end
endmodule

// File: rtl/scan_cfg_pick.sv
module scan_cfg_pick
  import scan_cfg_sel_pkg::*;
#(
  parameter int unsigned CNT_W = 4,
  localparam int unsigned COST_W = CNT_W + 3
) (
  input  logic [NUM_CFG-1:0] ok_i,
  input  logic [CNT_W-1:0]   tran_i [NUM_CFG],
  input  logic [1:0]         obj_i,
  output logic               any_o,
  output logic [CFG_W-1:0]   win_o
);
  logic [COST_W-1:0]   prim [NUM_CFG];
  logic [COST_W-1:0]   sec  [NUM_CFG];
  logic [2*COST_W-1:0] best;

  always_comb begin
    for (int k = 0; k < NUM_CFG; k++) begin
      logic [COST_W-1:0] nb, nt;
      nb = COST_W'(cfg_modulus(k));
      nt = COST_W'(tran_i[k]);
      unique case (obj_e'(obj_i))
        OBJ_PINS: begin prim[k] = nb;      sec[k] = nt; end
        OBJ_TRAN: begin prim[k] = nt;      sec[k] = nb; end
        default:  begin prim[k] = nt * nb; sec[k] = nt; end
      endcase
    end
    any_o = 1'b0;
    win_o = '0;
    best  = '1;
    // strict compare: remaining ties keep the lower code
    for (int k = 0; k < NUM_CFG; k++) begin
      if (ok_i[k] && (!any_o || {prim[k], sec[k]} < best)) begin
        any_o = 1'b1;
        win_o = CFG_W'(k);
        best  = {prim[k], sec[k]};
      end
    end
  end
endmodule

// File: rtl/scan_cfg_selector.sv
module scan_cfg_selector
  import scan_cfg_sel_pkg::*;
#(
  parameter int unsigned N_CHAINS = 14
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  output logic                ready_o,
  input  logic [N_CHAINS-1:0] care_i,
  input  logic [N_CHAINS-1:0] value_i,
  input  logic [1:0]          obj_i,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic                serial_o,
  output logic [CFG_W-1:0]    cfg_o,
  output logic [MAX_PINS-1:0] pins_o,
  output logic [N_CHAINS-1:0] slice_o
);
  localparam int unsigned CNT_W = $clog2(N_CHAINS + 1);

  logic [NUM_CFG-1:0]  ok_c;
  logic [MAX_PINS-1:0] pins_c [NUM_CFG];
  logic [N_CHAINS-1:0] fill_c [NUM_CFG];
  logic [CNT_W-1:0]    tran_c [NUM_CFG];
  logic                any_ok;
  logic [CFG_W-1:0]    win;
  logic [N_CHAINS-1:0] serial_fill;
  logic                fire;

  logic                out_valid_q, serial_q;
  logic [CFG_W-1:0]    cfg_q;
  logic [MAX_PINS-1:0] pins_q;
  logic [N_CHAINS-1:0] slice_q;

  for (genvar k = 0; k < NUM_CFG; k++) begin : g_cfg
    scan_cfg_eval #(
      .N_CHAINS(N_CHAINS),
      .MODULUS (cfg_modulus(k)),
      .CNT_W   (CNT_W)
    ) u_eval (
      .care_i      (care_i),
      .value_i     (value_i),
      .prev_slice_i(slice_q),
      .prev_pins_i (pins_q),
      .ok_o        (ok_c[k]),
      .pins_o      (pins_c[k]),
      .fill_o      (fill_c[k]),
      .tran_o      (tran_c[k])
    );
  end

  scan_cfg_pick #(.CNT_W(CNT_W)) u_pick (
    .ok_i  (ok_c),
    .tran_i(tran_c),
    .obj_i (obj_i),
    .any_o (any_ok),
    .win_o (win)
  );

  assign serial_fill = (care_i & value_i) | (~care_i & slice_q);
  assign ready_o     = !out_valid_q || out_ready_i;
  assign fire        = valid_i && ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      serial_q    <= 1'b0;
      cfg_q       <= '0;
      pins_q      <= '0;
      slice_q     <= '0;
    end else if (fire) begin
      out_valid_q <= 1'b1;
      serial_q    <= !any_ok;
      cfg_q       <= any_ok ? win : '0;
      pins_q      <= any_ok ? pins_c[win] : pins_q;
      slice_q     <= any_ok ? fill_c[win] : serial_fill;
    end else if (out_ready_i) begin
      out_valid_q <= 1'b0;
    end
  end

  assign out_valid_o = out_valid_q;
  assign serial_o    = serial_q;
  assign cfg_o       = cfg_q;
  assign pins_o      = pins_q;
  assign slice_o     = slice_q;
endmodule

// File: rtl/scan_cfg_selector_chk.sv
module scan_cfg_selector_chk
  import scan_cfg_sel_pkg::*;
#(
  parameter int unsigned N_CHAINS = 14
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                valid_i,
  input logic                ready_o,
  input logic [N_CHAINS-1:0] care_i,
  input logic [N_CHAINS-1:0] value_i,
  input logic                out_valid_o,
  input logic                out_ready_i,
  input logic                serial_o,
  input logic [CFG_W-1:0]    cfg_o,
  input logic [MAX_PINS-1:0] pins_o,
  input logic [N_CHAINS-1:0] slice_o
);
  logic in_fire;
  assign in_fire = valid_i && ready_o;

  function automatic logic map_ok(input logic [N_CHAINS-1:0] s,
                                  input logic [MAX_PINS-1:0] p,
                                  input logic [CFG_W-1:0] k);
    int unsigned m;
    m = cfg_modulus(k);
    for (int c = 0; c < N_CHAINS; c++) if (s[c] != p[c % m]) return 1'b0;
    return 1'b1;
  endfunction

  assert_care_kept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && $past(in_fire)) |->
      (((slice_o ^ $past(value_i)) & $past(care_i)) == '0));

  assert_pin_map_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !serial_o) |-> map_ok(slice_o, pins_o, cfg_o));

  assert_serial_pins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(in_fire) && serial_o) |-> (pins_o == $past(pins_o)));

  assert_serial_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && serial_o) |-> (cfg_o == '0));

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(slice_o) && $stable(cfg_o) && $stable(pins_o) && $stable(serial_o)));

  assert_stall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !ready_o);
endmodule

bind scan_cfg_selector scan_cfg_selector_chk #(.N_CHAINS(N_CHAINS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .ready_o    (ready_o),
  .care_i     (care_i),
  .value_i    (value_i),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .serial_o   (serial_o),
  .cfg_o      (cfg_o),
  .pins_o     (pins_o),
  .slice_o    (slice_o)
);

// File: tb/scan_cfg_selector_tb.sv
`timescale 1ns/1ps
module scan_cfg_selector_tb;
  localparam int N = 14;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic         ready_o;
  logic [N-1:0] care_i = '0;
  logic [N-1:0] value_i = '0;
  logic [1:0]   obj_i = '0;
  logic         out_valid_o;
  logic         out_ready_i = 1'b1;
  logic         serial_o;
  logic [1:0]   cfg_o;
  logic [6:0]   pins_o;
  logic [N-1:0] slice_o;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  logic [N-1:0] m_slice;
  logic [6:0]   m_pins;

  always #2.5 clk_i = ~clk_i;

  scan_cfg_selector #(.N_CHAINS(N)) u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model(input logic [N-1:0] care, input logic [N-1:0] val, input logic [1:0] obj,
                       output logic ser, output logic [1:0] cfg,
                       output logic [6:0] pins, output logic [N-1:0] sl);
    int best_p, best_s;
    bit found;
    found = 0; best_p = 0; best_s = 0;
    ser = 1'b1; cfg = 2'd0; pins = m_pins; sl = (care & val) | (~care & m_slice);
    for (int k = 0; k < 4; k++) begin
      int m, nt, pr, sc;
      bit ok;
      logic [6:0] p, set;
      logic [N-1:0] f;
      m = (k == 0) ? 2 : (k == 1) ? 3 : (k == 2) ? 5 : 7;
      ok = 1; p = m_pins; set = '0;
      for (int c = 0; c < N; c++) begin
        if (care[c]) begin
          if (set[c % m] && p[c % m] != val[c]) ok = 0;
          set[c % m] = 1'b1;
          p[c % m] = val[c];
        end
      end
      nt = 0;
      for (int c = 0; c < N; c++) begin
        f[c] = p[c % m];
        if (f[c] != m_slice[c]) nt++;
      end
      if (obj == 2'd0)      begin pr = m;      sc = nt; end
      else if (obj == 2'd1) begin pr = nt;     sc = m;  end
      else                  begin pr = nt * m; sc = nt; end
      if (ok && (!found || pr < best_p || (pr == best_p && sc < best_s))) begin
        found = 1; best_p = pr; best_s = sc;
        ser = 1'b0; cfg = 2'(k); pins = p; sl = f;
      end
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; valid_i = 1'b0; out_ready_i = 1'b1;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    m_slice = '0; m_pins = '0;
    @(negedge clk_i);
  endtask

  task automatic send(input logic [N-1:0] care, input logic [N-1:0] val,
                      input logic [1:0] obj, input string req);
    logic es; logic [1:0] ec; logic [6:0] ep; logic [N-1:0] esl;
    model(care, val, obj, es, ec, ep, esl);
    @(negedge clk_i);
    valid_i = 1'b1; care_i = care; value_i = val; obj_i = obj;
    @(negedge clk_i);
    valid_i = 1'b0;
    check({req, " valid"},  32'(out_valid_o), 32'd1);
    check({req, " serial"}, 32'(serial_o), 32'(es));
    check({req, " cfg"},    32'(cfg_o), 32'(ec));
    check({req, " pins"},   32'(pins_o), 32'(ep));
    check({req, " slice"},  32'(slice_o), 32'(esl));
    m_slice = esl; m_pins = ep;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] held;
    do_reset();
    // R1 reset state
    check("R1 out_valid", 32'(out_valid_o), 32'd0);
    check("R1 ready",     32'(ready_o), 32'd1);
    check("R1 slice",     32'(slice_o), 32'd0);
    check("R1 pins",      32'(pins_o), 32'd0);

    // single care bit on chain 0: R7 picks m=2, R6 and R8 pick m=7
    send(14'h0001, 14'h0001, 2'd0, "R7 fewest pins");
    check("R7 code", 32'(cfg_o), 32'd0);
    check("R5 m2 slice", 32'(slice_o), 32'h1555);
    do_reset();
    send(14'h0001, 14'h0001, 2'd1, "R6 fewest transitions");
    check("R6 code", 32'(cfg_o), 32'd3);
    check("R5 m7 slice", 32'(slice_o), 32'h0081);
    // no care bits: all pins repeat, m=7 gives zero transitions
    send(14'h0000, 14'h3fff, 2'd1, "R4 repeat fill");
    check("R4 code", 32'(cfg_o), 32'd3);
    check("R4 pins", 32'(pins_o), 32'h01);
    check("R4 slice", 32'(slice_o), 32'h0081);
    do_reset();
    // product tie 14 between m=2 and m=7, fewer transitions wins
    send(14'h0001, 14'h0001, 2'd2, "R8 product tie");
    check("R8 code", 32'(cfg_o), 32'd3);
    do_reset();
    // all-zero transitions tie under power: fewer pins wins
    send(14'h0000, 14'h0000, 2'd1, "R6 tie");
    check("R6 tie code", 32'(cfg_o), 32'd0);
    // every modulus conflicts on chains 0,2,3,5,7
    send(14'h00ad, 14'h0001, 2'd3, "R2 serial");
    check("R2 flag", 32'(serial_o), 32'd1);
    check("R9 serial slice", 32'(slice_o), 32'h0001);
    check("R9 serial pins", 32'(pins_o), 32'h00);

    // R10 backpressure
    send(14'h0102, 14'h0100, 2'd1, "R10 setup");
    held = slice_o;
    out_ready_i = 1'b0;
    @(negedge clk_i);
    valid_i = 1'b1; care_i = '1; value_i = 14'h2aaa;
    check("R10 ready low", 32'(ready_o), 32'd0);
    @(negedge clk_i);
    @(negedge clk_i);
    check("R10 held valid", 32'(out_valid_o), 32'd1);
    check("R10 held slice", 32'(slice_o), 32'(held));
    valid_i = 1'b0; out_ready_i = 1'b1;
    @(negedge clk_i);
    check("R10 drained", 32'(out_valid_o), 32'd0);

    // sweep over densities and objectives (R2..R9)
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      logic [N-1:0] a, b, c, care, val;
      a = N'($urandom); b = N'($urandom); c = N'($urandom);
      case (i % 4)
        0: care = a & b;
        1: care = a & b & c;
        2: care = a;
        default: care = a & b & c & N'($urandom);
      endcase
      val = N'($urandom);
      send(care, val, 2'(i / 4), "R2-R9 sweep");
      if (i % 97 == 0) begin
        check("R3 care kept", 32'((slice_o ^ val) & care), 32'd0);
      end
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule